// File: doc/BRIEF.md
# Reconfigurable Lifting Step Element

This block is one processing element of a lifting-scheme wavelet datapath. It takes a stream of sample pairs. Each pair carries one even sample `x[2n]` and the odd sample before it, `x[2n-1]`. The element applies one or more lifting steps to the stream. A single arithmetic cell computes `D = A + round(coef * f(B, C))`, where `f` is a sum, a difference, a single tap or nothing. An operand multiplexer feeds the cell from the incoming pair, from per-step lifting state and from a feedback register. The element drives its result pair out through a pipeline register, in the same lagged even/odd form that it accepts, so several elements can be chained back to back.

A configuration word selects the number of steps executed per pair. It also sets, for each step slot, the cell form, which half of the pair is updated, and the coefficient. When two steps are configured, the one cell is folded. It runs the first step on the input pair and the second step on the fed-back pair in the next cycle, and it accepts a new pair only every other cycle. A first-of-line flag travels with every pair. On a flagged pair the lifting state of the previous pair reads as zero, which gives a defined boundary at the start of every line.

Top module: `lift_pe`

## Requirements
- R1: Cell form code 0 (symmetric) computes `D = sat(A + ((coef*(B+C) + 2^(FRAC-1)) >>> FRAC))`. `coef` is a signed CW-bit value with FRAC fractional bits, and `sat` clamps to the signed DW-bit range.
- R2: Cell form code 1 (anti-symmetric) computes the same expression with `B-C` in place of `B+C`.
- R3: Cell form code 2 (single tap) computes the same expression with `B` alone.
- R4: Cell form code 3 (bypass) gives `D = A` unchanged.
- R5: A step with target bit 0 updates the odd half. It takes `A` = incoming odd, `B` = previous even, `C` = incoming even, and emits the pair (incoming even, D).
- R6: A step with target bit 1 updates the even half. It takes `A` = previous even, `B` = incoming odd, `C` = previous odd, and emits the pair (D, previous odd). The even result therefore belongs to the pair before.
- R7: On a pair whose first-of-line flag is set, the previous even and previous odd of that step slot read as zero. `out_first` repeats the flag of the pair that produced the output.
- R8: With steps field 1 (two steps), slot 0 runs on the input pair and slot 1 runs on the slot-0 result in the next cycle. `in_ready` is low for exactly that one cycle after each accepted pair. With steps field 0, `in_ready` stays high.
- R9: A result pair appears with `out_valid` high for one cycle. It arrives one cycle after acceptance with one step, and two cycles after acceptance with two steps.
- R10: The configuration word is taken in only on a cycle where `cfg_load` is high, `in_ready` is high and `in_valid` is low. Otherwise it is ignored. Layout: bit 0 = steps minus one. Slot i occupies bits 1+15i upward, with form code in [1:0], target bit in [2] and coefficient in [14:3].
- R11: After reset `out_valid` is low, `in_ready` is high and the configuration is all zero. That is one symmetric odd-target step with coefficient 0, so the odd half passes unchanged.
- R12: Results beyond the DW-bit signed range saturate to 32767 or -32768 for the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Request to take in `cfg_word` |
| cfg_word | input | 31 | Step count and per-slot form, target and coefficient |
| in_valid | input | 1 | Input pair present |
| in_first | input | 1 | Input pair is the first of a line |
| in_even | input | 16 | Even sample x[2n], signed |
| in_odd | input | 16 | Odd sample x[2n-1], signed |
| in_ready | output | 1 | Element can accept a pair this cycle |
| out_valid | output | 1 | Result pair present |
| out_first | output | 1 | Result pair starts a line |
| out_even | output | 16 | Even result, signed |
| out_odd | output | 16 | Odd result, signed |

## Verification
The assertions take two things for granted. First, `in_valid` is offered only with a clean reset behind it. Second, the pairs of a line are not interleaved with a configuration change, so the configuration seen at acceptance is still in force when the result emerges. The bench loads configurations only between lines, with the input idle. The single exception is deliberate: it drives a load alongside a valid pair and during the fold stall, and there the ignore rule must keep the old setting. Every input pair is driven only when `in_ready` is high, so the one-cycle fold stall is respected. The data come from a deterministic generator, with extreme-value lines added to reach saturation.

// File: rtl/lift_pkg.sv
// Package: shared encodings for the lifting step element.
// Assumes: form codes are two bits wide and fixed by the configuration layout.
package lift_pkg;
    typedef enum logic [1:0] {
        MD_SYM    = 2'd0,
        MD_ANTI   = 2'd1,
        MD_SINGLE = 2'd2,
        MD_PASS   = 2'd3
    } lift_mode_e;
endpackage

// File: rtl/lift_cell.sv
// Core arithmetic cell: D = A + round(coef * f(B, C)), saturated to DW bits.
// Assumes: coef is signed with FRAC fractional bits; purely combinational.
module lift_cell #(
    parameter int DW   = 16,
    parameter int CW   = 12,
    parameter int FRAC = 11
) (
    input  logic [1:0]           mode,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    input  logic signed [DW-1:0] c,
    input  logic signed [CW-1:0] coef,
    output logic signed [DW-1:0] d
);
    localparam int SUMW = DW + 1;
    localparam int PW   = SUMW + CW;
    localparam int TW   = PW + 1;
    localparam int HALF = 1 << (FRAC - 1);
    localparam logic signed [DW-1:0] DMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] DMIN = {1'b1, {(DW-1){1'b0}}};

    logic signed [SUMW-1:0] s;
    logic signed [PW-1:0]   p;
    logic signed [PW-1:0]   pr;
    logic signed [TW-1:0]   t;

    // Operand combine, multiply, round, add and clamp.
    always_comb begin
        case (mode)
            lift_pkg::MD_SYM:  s = SUMW'(b) + SUMW'(c);
            lift_pkg::MD_ANTI: s = SUMW'(b) - SUMW'(c);
            default:           s = SUMW'(b);
        endcase
        p  = PW'(s) * PW'(coef);
        pr = (p + PW'(HALF)) >>> FRAC;
        t  = TW'(a) + TW'(pr);
        if (mode == lift_pkg::MD_PASS)
            d = a;
        else if (t > TW'(DMAX))
            d = DMAX;
        else if (t < TW'(DMIN))
            d = DMIN;
        else
            d = t[DW-1:0];
    end
endmodule

// File: rtl/lift_cfg_dec.sv
// Configuration register and decoder: splits the word into step count and
// per-slot form, target and coefficient.
// Assumes: load_en is already qualified by the idle condition.
module lift_cfg_dec #(
    parameter int F  = 2,
    parameter int CW = 12,
    parameter int SW = 1,
    parameter int CFGW = SW + F * (CW + 3)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic [CFGW-1:0]        word,
    output logic [SW-1:0]          steps_m1,
    output logic [F-1:0][1:0]      cmode,
    output logic [F-1:0]           ctgt,
    output logic [F-1:0][CW-1:0]   ccoef
);
    localparam int SLOTW = CW + 3;

    logic [SW-1:0] steps_w;

    // Clamp a step count beyond the slot count to the last slot.
    always_comb begin
        steps_w = (word[SW-1:0] > SW'(F - 1)) ? SW'(F - 1) : word[SW-1:0];
    end

    // Step count register.
    always_ff @(posedge clk) begin
        if (!rst_n)       steps_m1 <= '0;
        else if (load_en) steps_m1 <= steps_w;
    end

    for (genvar i = 0; i < F; i++) begin : g_slot
        // Per-slot field register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmode[i] <= '0;
                ctgt[i]  <= 1'b0;
                ccoef[i] <= '0;
            end else if (load_en) begin
                cmode[i] <= word[SW + i*SLOTW +: 2];
                ctgt[i]  <= word[SW + i*SLOTW + 2];
                ccoef[i] <= word[SW + i*SLOTW + 3 +: CW];
            end
        end
    end
endmodule

// File: rtl/lift_lstate.sv
// Lifting state of one step slot: the previous even and odd operands it saw.
// Assumes: upd pulses once per pair handled by this slot.
module lift_lstate #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic signed [DW-1:0] pe,
    input  logic signed [DW-1:0] po,
    output logic signed [DW-1:0] ep,
    output logic signed [DW-1:0] op
);
    // Capture the slot's input pair for use by the next pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ep <= '0;
            op <= '0;
        end else if (upd) begin
            ep <= pe;
            op <= po;
        end
    end
endmodule

// File: rtl/lift_pe.sv
// Reconfigurable lifting step element. One cell is time-shared over up to F
// step slots. Chain 0 is the feedback pair, chain 1 the per-slot lifting state,
// chain 2 the output pipeline register.
// Assumes: configuration is changed only between lines; pairs arrive in
// lagged form (even x[2n], odd x[2n-1]).
module lift_pe #(
    parameter int DW   = 16,
    parameter int CW   = 12,
    parameter int FRAC = 11,
    parameter int F    = 2,
    localparam int SW    = (F > 1) ? $clog2(F) : 1,
    localparam int CFGW  = SW + F * (CW + 3)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic [CFGW-1:0]      cfg_word,
    input  logic                 in_valid,
    input  logic                 in_first,
    input  logic signed [DW-1:0] in_even,
    input  logic signed [DW-1:0] in_odd,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic                 out_first,
    output logic signed [DW-1:0] out_even,
    output logic signed [DW-1:0] out_odd
);
    logic [SW-1:0]        steps_m1;
    logic [F-1:0][1:0]    cmode;
    logic [F-1:0]         ctgt;
    logic [F-1:0][CW-1:0] ccoef;
    logic [SW-1:0]        phase;
    logic                 fb_first;
    logic signed [DW-1:0] fb_e, fb_o;
    logic signed [DW-1:0] bank_e [F];
    logic signed [DW-1:0] bank_o [F];
    logic                 accept, step_go, last_step, load_en;
    logic                 sel_f, tgt_c;
    logic signed [DW-1:0] sel_e, sel_o, ep_c, op_c, op_a, op_b, op_cc, cell_d;
    logic signed [DW-1:0] res_e, res_o;
    logic [1:0]           mode_c;
    logic signed [CW-1:0] coef_c;

    assign in_ready  = (phase == '0);
    assign accept    = in_valid && in_ready;
    assign step_go   = accept || (phase != '0);
    assign last_step = (phase == steps_m1);
    assign load_en   = cfg_load && in_ready && !in_valid;

    lift_cfg_dec #(.F(F), .CW(CW), .SW(SW), .CFGW(CFGW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .word(cfg_word),
        .steps_m1(steps_m1), .cmode(cmode), .ctgt(ctgt), .ccoef(ccoef)
    );

    for (genvar i = 0; i < F; i++) begin : g_bank
        lift_lstate #(.DW(DW)) u_state (
            .clk(clk), .rst_n(rst_n),
            .upd(step_go && (phase == SW'(i))),
            .pe(sel_e), .po(sel_o), .ep(bank_e[i]), .op(bank_o[i])
        );
    end

    // Operand multiplexer: pick the pair, the slot state and the cell operands.
    always_comb begin
        sel_e  = (phase == '0) ? in_even  : fb_e;
        sel_o  = (phase == '0) ? in_odd   : fb_o;
        sel_f  = (phase == '0) ? in_first : fb_first;
        mode_c = cmode[phase];
        tgt_c  = ctgt[phase];
        coef_c = ccoef[phase];
        ep_c   = sel_f ? '0 : bank_e[phase];
        op_c   = sel_f ? '0 : bank_o[phase];
        if (!tgt_c) begin
            op_a = sel_o; op_b = ep_c; op_cc = sel_e;
        end else begin
            op_a = ep_c;  op_b = sel_o; op_cc = op_c;
        end
    end

    lift_cell #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_cell (
        .mode(mode_c), .a(op_a), .b(op_b), .c(op_cc), .coef(coef_c), .d(cell_d)
    );

    // Route the cell result into the half of the pair the step updates.
    always_comb begin
        res_e = tgt_c ? cell_d : sel_e;
        res_o = tgt_c ? op_c   : cell_d;
    end

    // Fold sequencer: advance through the configured slots.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (step_go) phase <= last_step ? '0 : phase + 1'b1;
    end

    // Feedback chain: hold an intermediate pair for the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_e <= '0; fb_o <= '0; fb_first <= 1'b0;
        end else if (step_go && !last_step) begin
            fb_e <= res_e; fb_o <= res_o; fb_first <= sel_f;
        end
    end

    // Output pipeline register with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_first <= 1'b0;
            out_even  <= '0;   out_odd   <= '0;
        end else begin
            out_valid <= step_go && last_step;
            if (step_go && last_step) begin
                out_first <= sel_f; out_even <= res_e; out_odd <= res_o;
            end
        end
    end
endmodule

// File: rtl/lift_pe_chk.sv
// Property checker for lift_pe, attached by bind.
// Assumes: reset is held for at least one clock before traffic.
module lift_pe_chk #(
    parameter int DW = 16,
    parameter int F  = 2,
    parameter int SW = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic signed [DW-1:0] in_even,
    input logic signed [DW-1:0] in_odd,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_even,
    input logic signed [DW-1:0] out_odd,
    input logic [SW-1:0]        steps_m1,
    input logic [1:0]           mode0,
    input logic                 tgt0
);
    logic [SW+1:0] stall_cnt;

    // Count consecutive cycles with the input side stalled.
    always_ff @(posedge clk) begin
        if (!rst_n)        stall_cnt <= '0;
        else if (in_ready) stall_cnt <= '0;
        else               stall_cnt <= stall_cnt + 1'b1;
    end

    a_r8_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stall_cnt < (SW+2)'(F));

    a_r8_single_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (steps_m1 == '0) |-> in_ready);

    a_r9_out_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid && in_ready) || $past(!in_ready)));

    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready || in_valid) |=> $stable({steps_m1, mode0, tgt0}));

    a_r4_pass_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (steps_m1 == '0 && mode0 == 2'd3 && !tgt0 && in_valid && in_ready)
        |=> (out_valid && out_odd == $past(in_odd)));

    a_r5_even_through: assert property (@(posedge clk) disable iff (!rst_n)
        (steps_m1 == '0 && !tgt0 && in_valid && in_ready)
        |=> (out_valid && out_even == $past(in_even)));
endmodule

bind lift_pe lift_pe_chk #(.DW(DW), .F(F), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_even(in_even), .in_odd(in_odd), .out_valid(out_valid),
    .out_even(out_even), .out_odd(out_odd), .steps_m1(steps_m1),
    .mode0(cmode[0]), .tgt0(ctgt[0])
);

// File: tb/lift_pe_tb.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps forms, targets, coefficients and fold depth,
// comparing every output pair with an arithmetic model of the requirements.
module lift_pe_tb;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_load = 1'b0;
    logic [30:0]        cfg_word = '0;
    logic               in_valid = 1'b0;
    logic               in_first = 1'b0;
    logic signed [15:0] in_even = '0;
    logic signed [15:0] in_odd = '0;
    logic               in_ready, out_valid, out_first;
    logic signed [15:0] out_even, out_odd;

    int    total = 0;
    int    fails = 0;
    string cur_req = "R11";
    int    qe[$], qo[$], qf[$];
    int    m_ep[2], m_op[2];
    int    c_steps = 1;
    int    c_md[2], c_tg[2], c_cf[2];
    int    seed = 7;
    bit    pulse_cfg = 1'b0;
    logic [30:0] bad_word = '0;

    always #2.5 clk = ~clk;

    lift_pe u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .in_valid(in_valid), .in_first(in_first), .in_even(in_even),
        .in_odd(in_odd), .in_ready(in_ready), .out_valid(out_valid),
        .out_first(out_first), .out_even(out_even), .out_odd(out_odd)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // Cell arithmetic from R1..R4 and R12.
    function automatic int cell_ref(input int md, input int a, input int b,
                                    input int c, input int cf);
        longint s, r;
        if (md == 3) return a;
        s = (md == 0) ? longint'(b) + c : (md == 1) ? longint'(b) - c : longint'(b);
        r = (s * cf + 1024) >>> 11;
        return sat16(longint'(a) + r);
    endfunction

    // One lifting step of slot k per R5, R6 and R7.
    task automatic mstep(input int k, input int pe, input int po, input bit pf,
                         output int re, output int ro);
        int ep, op, d;
        ep = pf ? 0 : m_ep[k];
        op = pf ? 0 : m_op[k];
        m_ep[k] = pe;
        m_op[k] = po;
        if (c_tg[k] == 0) begin
            d = cell_ref(c_md[k], po, ep, pe, c_cf[k]);
            re = pe; ro = d;
        end else begin
            d = cell_ref(c_md[k], ep, po, op, c_cf[k]);
            re = d; ro = op;
        end
    endtask

    function automatic logic [30:0] pack(input int st, input int md0, input int tg0,
                                         input int cf0, input int md1, input int tg1,
                                         input int cf1);
        logic [30:0] w;
        w = '0;
        w[0]     = 1'(st - 1);
        w[2:1]   = 2'(md0);
        w[3]     = 1'(tg0);
        w[15:4]  = 12'(cf0);
        w[17:16] = 2'(md1);
        w[18]    = 1'(tg1);
        w[30:19] = 12'(cf1);
        return w;
    endfunction

    task automatic load_cfg(input int st, input int md0, input int tg0, input int cf0,
                            input int md1, input int tg1, input int cf1);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b0;
        cfg_word = pack(st, md0, tg0, cf0, md1, tg1, cf1);
        cfg_load = 1'b1;
        @(posedge clk);
        #1 cfg_load = 1'b0;
        c_steps = st;
        c_md[0] = md0; c_tg[0] = tg0; c_cf[0] = cf0;
        c_md[1] = md1; c_tg[1] = tg1; c_cf[1] = cf1;
    endtask

    task automatic send(input int e, input int o, input bit f);
        int pe, po, re, ro;
        @(negedge clk);
        while (!in_ready) begin in_valid = 1'b0; @(negedge clk); end
        in_valid = 1'b1; in_even = 16'(e); in_odd = 16'(o); in_first = f;
        if (pulse_cfg) begin cfg_word = bad_word; cfg_load = 1'b1; end
        pe = e; po = o;
        for (int k = 0; k < c_steps; k++) begin
            mstep(k, pe, po, f, re, ro);
            pe = re; po = ro;
        end
        qe.push_back(pe); qo.push_back(po); qf.push_back(int'(f));
        @(posedge clk);
        #1 cfg_load = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    function automatic int gen();
        seed = seed * 1103515245 + 12345;
        return int'($signed(16'(seed >>> 9)));
    endfunction

    task automatic run_line(input int n, input bit extreme);
        for (int i = 0; i < n; i++) begin
            if (extreme) send((i % 2) ? 32767 : -32768, ((i / 2) % 2) ? 32767 : -32768, i == 0);
            else         send(gen(), gen(), i == 0);
        end
        drain();
    endtask

    // Output monitor: every result pair against the model queue (R9 ordering).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (qe.size() == 0) begin
                check("R9", 1'b0, 1, 0);
            end else begin
                int e, o, f;
                e = qe.pop_front(); o = qo.pop_front(); f = qf.pop_front();
                check(cur_req, int'(out_even) == e, int'(out_even), e);
                check(cur_req, int'(out_odd) == o, int'(out_odd), o);
                check("R7", int'(out_first) == f, int'(out_first), f);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        static string mtag[4] = '{"R1", "R2", "R3", "R4"};
        static string ttag[2] = '{"R5", "R6"};
        static int coefs[4] = '{-1624, 905, 2047, -2048};
        for (int k = 0; k < 2; k++) begin
            c_md[k] = 0; c_tg[k] = 0; c_cf[k] = 0; m_ep[k] = 0; m_op[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R11", out_valid == 1'b0, int'(out_valid), 0);
        check("R11", in_ready == 1'b1, int'(in_ready), 1);
        cur_req = "R11";
        run_line(6, 1'b0);

        // R9 latency with one step.
        load_cfg(1, 0, 0, 905, 0, 0, 0);
        cur_req = "R9";
        send(100, -50, 1'b1);
        @(negedge clk) in_valid = 1'b0;
        check("R9", out_valid == 1'b1, int'(out_valid), 1);
        @(negedge clk);
        check("R9", out_valid == 1'b0, int'(out_valid), 0);
        drain();

        // R8 fold stall and two-cycle latency.
        load_cfg(2, 0, 0, 905, 1, 1, -1624);
        cur_req = "R8";
        send(300, 200, 1'b1);
        @(negedge clk) in_valid = 1'b0;
        check("R8", in_ready == 1'b0, int'(in_ready), 0);
        check("R9", out_valid == 1'b0, int'(out_valid), 0);
        @(negedge clk);
        check("R8", in_ready == 1'b1, int'(in_ready), 1);
        check("R9", out_valid == 1'b1, int'(out_valid), 1);
        drain();

        // R10: loads during a valid pair and during the stall are ignored.
        load_cfg(2, 2, 0, 1500, 0, 1, -700);
        cur_req = "R10";
        bad_word = pack(1, 3, 0, 0, 3, 0, 0);
        pulse_cfg = 1'b1;
        send(1000, -2000, 1'b1);
        pulse_cfg = 1'b0;
        cfg_word = bad_word; cfg_load = 1'b1;
        @(posedge clk);
        #1 cfg_load = 1'b0;
        for (int i = 1; i < 8; i++) send(gen(), gen(), 1'b0);
        drain();

        // R7: back-to-back lines, state must restart at zero.
        load_cfg(1, 0, 1, 1800, 0, 0, 0);
        cur_req = "R7";
        run_line(5, 1'b0);
        run_line(5, 1'b0);

        // One-step sweep over form, target and coefficient.
        for (int md = 0; md < 4; md++)
            for (int tg = 0; tg < 2; tg++)
                for (int ci = 0; ci < 4; ci++) begin
                    load_cfg(1, md, tg, coefs[ci], 0, 0, 0);
                    cur_req = $sformatf("%s %s", mtag[md], ttag[tg]);
                    run_line(10, 1'b0);
                end

        // Saturation lines.
        for (int md = 0; md < 3; md++) begin
            load_cfg(1, md, 0, 2047, 0, 0, 0);
            cur_req = "R12";
            run_line(8, 1'b1);
            load_cfg(1, md, 1, -2048, 0, 0, 0);
            run_line(8, 1'b1);
        end

        // Folded two-step sweep.
        for (int m0 = 0; m0 < 4; m0++)
            for (int m1 = 0; m1 < 4; m1++)
                for (int tp = 0; tp < 2; tp++) begin
                    load_cfg(2, m0, tp, coefs[(m0 + tp) % 4], m1, 1 - tp, coefs[(m1 + 2) % 4]);
                    cur_req = "R8";
                    run_line(10, (m0 == m1) && tp == 1);
                end

        drain();
        check("R9", qe.size() == 0, qe.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule